// File: doc/BRIEF.md
# Parallel Template Instantiator with Sharing Flags

The block copies one function-body template onto a graph heap, two applications per clock cycle. Each application is a row of atoms. Every atom is rewritten on its way to the heap. An argument reference is swapped for the matching entry of the reduction-stack window. A relative application pointer is turned into an absolute heap address. Integer and function atoms are copied as they are. Each atom carries a one-bit sharing flag. When the template marks an argument as used more than once in the body, the copied pointer has its sharing flag forced on ("dashed"). The block does this as it instantiates the body, so no separate sharing analysis is needed.

A reduction controller pulses `start` with the number of applications in the body, the current heap size and the stack window. The block asks for template rows through `tmpl_idx` and reads `tmpl_word` in the same cycle, so the template memory is read combinationally. It issues up to two heap writes per cycle, advances the heap size as it goes, and pulses `done` at the end. The control path is a three-state machine:
- **IDLE** waits for `start`. From IDLE it takes *begin* to RUN, or *skip* to DONE when the body is empty.
- **RUN** emits one template row per cycle. It takes *finish* to DONE when two or fewer applications remain.
- **DONE** lasts one cycle, then takes *return* back to IDLE.

Atom layout, for an atom width of PW+3 bits:
- bits [PW+2:PW+1] hold the kind: 00 integer, 01 function, 10 argument, 11 application.
- bit [PW] is the sharing flag.
- bits [PW-1:0] are the payload. For an argument, payload bits [3:0] hold the stack index.

A heap row packs atom 0 in its lowest bits. `tmpl_word` packs application 0 (lane 0) in its low half.

Top module: `tmpl_instantiator`

## Requirements
- R1: An argument atom (kind 10) is replaced by the stack-window entry chosen by its payload bits [3:0]. The entry's kind and payload are copied unchanged.
- R2: If an argument atom has its sharing flag set, the written atom's sharing flag is 1. Otherwise the written atom keeps the sharing flag of the stack entry.
- R3: An application atom (kind 11) is written as kind 11 with payload equal to the heap size captured at `start` plus its own payload, modulo 2^PW. Its sharing flag is taken from the template.
- R4: Integer (00) and function (01) atoms are written bit for bit as in the template, including the sharing flag.
- R5: Lane 0 writes at the current heap size and lane 1 writes at the next address. A body of n applications is written in ceil(n/2) RUN cycles. When n is odd, lane 1 is not written in the last cycle.
- R6: `hsize_out` takes `hsize_in` at `start`. It then grows by the number of applications written in each cycle, so it equals `hsize_in` + n when `done` is high.
- R7: An argument index of 8 or more (outside the window) writes an all-zero atom and sets `arg_err`. `arg_err` stays set until the next accepted `start`, which clears it.
- R8: With n = 0, `done` pulses one cycle after `start`. No heap write happens and `hsize_out` stays at `hsize_in`.
- R9: `start` is ignored while `busy` is high. The running instantiation keeps its count and its heap base.
- R10: After reset, `busy`, `done`, `arg_err` and `heap_we` are 0, and `hsize_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instantiation (accepted in IDLE) |
| n_apps | input | CW | Number of applications in the body |
| hsize_in | input | PW | Heap size at start |
| stack_win | input | DEPTH*(PW+3) | Top stack entries, entry 0 lowest |
| tmpl_word | input | 2*ATOMS*(PW+3) | Template row pair addressed by tmpl_idx |
| tmpl_idx | output | CW | Template row-pair index being read |
| busy | output | 1 | Not in IDLE |
| done | output | 1 | One-cycle completion pulse |
| heap_we | output | 2 | Per-lane heap write enable |
| heap_addr0 | output | PW | Lane 0 heap address |
| heap_addr1 | output | PW | Lane 1 heap address |
| heap_data0 | output | ATOMS*(PW+3) | Lane 0 rewritten application |
| heap_data1 | output | ATOMS*(PW+3) | Lane 1 rewritten application |
| hsize_out | output | PW | Running heap size |
| arg_err | output | 1 | Out-of-window argument seen |

## Verification
The bench uses the default parameters: ATOMS=4, PW=12, DEPTH=8, IXW=4 and CW=8. With a 4-bit index field and an 8-entry window, indexes 8 to 15 can be written into a template, so the out-of-window path is reachable. With four atoms per application, a single heap row can mix all four atom kinds. Bodies of 0, 1, 2, 3 and 4 applications cover the empty path, the odd-length lane-1 drop, and a start pulse that arrives while a run is in progress.

// File: rtl/tinst_pkg.sv
package tinst_pkg;

    typedef enum logic [1:0] {
        K_INT = 2'b00,
        K_FUN = 2'b01,
        K_ARG = 2'b10,
        K_APP = 2'b11
    } kind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } state_t;

endpackage

// File: rtl/tinst_atom_rewrite.sv
module tinst_atom_rewrite
    import tinst_pkg::*;
#(
    parameter int PW    = 12,
    parameter int DEPTH = 8,
    parameter int IXW   = 4
) (
    input  logic [PW+2:0]           tmpl_atom,
    input  logic [DEPTH*(PW+3)-1:0] stack_win,
    input  logic [PW-1:0]           base,
    output logic [PW+2:0]           out_atom,
    output logic                    bad
);
    localparam int ATW  = PW + 3;
    localparam int SELW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IXW:0] DEPTH_L = (IXW+1)'(DEPTH);

    kind_t           kind;
    logic            sh;
    logic [PW-1:0]   pl;
    logic [IXW-1:0]  idx;
    logic [ATW-1:0]  ent_a [DEPTH];
    logic [ATW-1:0]  ent;
    logic            in_range;

    for (genvar e = 0; e < DEPTH; e++) begin : g_unpack
        assign ent_a[e] = stack_win[e*ATW +: ATW];
    end

    always_comb begin
        kind     = kind_t'(tmpl_atom[ATW-1 -: 2]);
        sh       = tmpl_atom[PW];
        pl       = tmpl_atom[PW-1:0];
        idx      = pl[IXW-1:0];
        in_range = ({1'b0, idx} < DEPTH_L);
        ent      = ent_a[idx[SELW-1:0]];
    end

    always_comb begin
        out_atom = tmpl_atom;
        bad      = 1'b0;
        unique case (kind)
            K_ARG: begin
                if (in_range) begin
                    out_atom = {ent[ATW-1 -: 2], ent[PW] | sh, ent[PW-1:0]};
                end else begin
                    out_atom = '0;
                    bad      = 1'b1;
                end
            end
            K_APP: out_atom = {K_APP, sh, base + pl};
            K_INT: out_atom = tmpl_atom;
            K_FUN: out_atom = tmpl_atom;
            default: out_atom = tmpl_atom;
        endcase
    end

    // R2: a dashed in-range argument always leaves with its sharing flag on
    always_comb begin
        if (kind == K_ARG && in_range && sh)
            assert_dash_set_R2: assert (out_atom[PW] == 1'b1);
    end

    // R7: an out-of-window argument yields an all-zero atom
    always_comb begin
        if (bad)
            assert_bad_zero_R7: assert (out_atom == '0);
    end

endmodule

// File: rtl/tinst_lane.sv
module tinst_lane #(
    parameter int ATOMS = 4,
    parameter int PW    = 12,
    parameter int DEPTH = 8,
    parameter int IXW   = 4
) (
    input  logic [ATOMS*(PW+3)-1:0] tmpl_app,
    input  logic [DEPTH*(PW+3)-1:0] stack_win,
    input  logic [PW-1:0]           base,
    output logic [ATOMS*(PW+3)-1:0] app_out,
    output logic                    bad
);
    localparam int ATW = PW + 3;

    logic [ATOMS-1:0] bad_v;

    for (genvar a = 0; a < ATOMS; a++) begin : g_atom
        tinst_atom_rewrite #(
            .PW(PW), .DEPTH(DEPTH), .IXW(IXW)
        ) u_rw (
            .tmpl_atom (tmpl_app[a*ATW +: ATW]),
            .stack_win (stack_win),
            .base      (base),
            .out_atom  (app_out[a*ATW +: ATW]),
            .bad       (bad_v[a])
        );
    end

    assign bad = |bad_v;

endmodule

// File: rtl/tinst_ctrl.sv
module tinst_ctrl
    import tinst_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] n_apps,
    output state_t        state,
    output logic [CW-1:0] slice,
    output logic          run,
    output logic          lane1_on,
    output logic          busy,
    output logic          done
);
    state_t        nxt;
    logic [CW-1:0] rem;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions: begin, skip, finish, return
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = (n_apps == '0) ? S_DONE : S_RUN;
            S_RUN:  if (rem <= CW'(2)) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // remaining-work and row counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            slice <= '0;
        end else if (state == S_IDLE && start) begin
            rem   <= n_apps;
            slice <= '0;
        end else if (state == S_RUN) begin
            rem   <= rem - (lane1_on ? CW'(2) : CW'(1));
            slice <= slice + CW'(1);
        end
    end

    // outputs
    always_comb begin
        run      = (state == S_RUN);
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        lane1_on = run && (rem >= CW'(2));
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_return_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |=> (state == S_IDLE));

    assert_run_has_work_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rem != '0));

endmodule

// File: rtl/tmpl_instantiator.sv
module tmpl_instantiator
    import tinst_pkg::*;
#(
    parameter int ATOMS = 4,
    parameter int PW    = 12,
    parameter int DEPTH = 8,
    parameter int IXW   = 4,
    parameter int CW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [CW-1:0]             n_apps,
    input  logic [PW-1:0]             hsize_in,
    input  logic [DEPTH*(PW+3)-1:0]   stack_win,
    input  logic [2*ATOMS*(PW+3)-1:0] tmpl_word,
    output logic [CW-1:0]             tmpl_idx,
    output logic                      busy,
    output logic                      done,
    output logic [1:0]                heap_we,
    output logic [PW-1:0]             heap_addr0,
    output logic [PW-1:0]             heap_addr1,
    output logic [ATOMS*(PW+3)-1:0]   heap_data0,
    output logic [ATOMS*(PW+3)-1:0]   heap_data1,
    output logic [PW-1:0]             hsize_out,
    output logic                      arg_err
);
    localparam int ATW  = PW + 3;
    localparam int APPW = ATOMS * ATW;
    localparam int SWW  = DEPTH * ATW;

    state_t          state;
    logic            run;
    logic            lane1_on;
    logic [PW-1:0]   base;
    logic [PW-1:0]   hp;
    logic [SWW-1:0]  stk;
    logic [APPW-1:0] lane_out [2];
    logic [1:0]      lane_bad;

    tinst_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .n_apps   (n_apps),
        .state    (state),
        .slice    (tmpl_idx),
        .run      (run),
        .lane1_on (lane1_on),
        .busy     (busy),
        .done     (done)
    );

    for (genvar l = 0; l < 2; l++) begin : g_lane
        tinst_lane #(
            .ATOMS(ATOMS), .PW(PW), .DEPTH(DEPTH), .IXW(IXW)
        ) u_lane (
            .tmpl_app  (tmpl_word[l*APPW +: APPW]),
            .stack_win (stk),
            .base      (base),
            .app_out   (lane_out[l]),
            .bad       (lane_bad[l])
        );
    end

    // capture on begin/skip, heap size and error bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= '0;
            hp      <= '0;
            stk     <= '0;
            arg_err <= 1'b0;
        end else if (state == S_IDLE && start) begin
            base    <= hsize_in;
            hp      <= hsize_in;
            stk     <= stack_win;
            arg_err <= 1'b0;
        end else if (run) begin
            hp      <= hp + (lane1_on ? PW'(2) : PW'(1));
            arg_err <= arg_err | lane_bad[0] | (lane1_on & lane_bad[1]);
        end
    end

    // registered heap write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            heap_we    <= 2'b00;
            heap_addr0 <= '0;
            heap_addr1 <= '0;
            heap_data0 <= '0;
            heap_data1 <= '0;
        end else if (run) begin
            heap_we    <= {lane1_on, 1'b1};
            heap_addr0 <= hp;
            heap_addr1 <= hp + PW'(1);
            heap_data0 <= lane_out[0];
            heap_data1 <= lane_out[1];
        end else begin
            heap_we    <= 2'b00;
        end
    end

    assign hsize_out = hp;

    assert_lane_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        heap_we[1] |-> (heap_we[0] && heap_addr1 == heap_addr0 + PW'(1)));

    assert_addr_follows_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        heap_we[0] |-> (heap_addr0 == $past(hsize_out)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (heap_we == 2'b00));

    assert_busy_keeps_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(base));

endmodule

// File: tb/tmpl_instantiator_test.sv
module tmpl_instantiator_test;
    import tinst_pkg::*;

    localparam int ATOMS = 4;
    localparam int PW    = 12;
    localparam int DEPTH = 8;
    localparam int IXW   = 4;
    localparam int CW    = 8;
    localparam int ATW   = PW + 3;
    localparam int APPW  = ATOMS * ATW;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [CW-1:0]         n_apps = '0;
    logic [PW-1:0]         hsize_in = '0;
    logic [DEPTH*ATW-1:0]  stack_win = '0;
    logic [2*APPW-1:0]     tmpl_word;
    logic [CW-1:0]         tmpl_idx;
    logic                  busy, done, arg_err;
    logic [1:0]            heap_we;
    logic [PW-1:0]         heap_addr0, heap_addr1, hsize_out;
    logic [APPW-1:0]       heap_data0, heap_data1;

    logic [2*APPW-1:0]     tm [16];
    logic [APPW-1:0]       hm [256];
    logic                  hw [256];
    int                    n_chk = 0;
    int                    n_bad = 0;
    int                    cyc;
    int                    wrc;

    always #2 clk = ~clk;

    assign tmpl_word = tm[tmpl_idx[3:0]];

    tmpl_instantiator #(
        .ATOMS(ATOMS), .PW(PW), .DEPTH(DEPTH), .IXW(IXW), .CW(CW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_apps(n_apps),
        .hsize_in(hsize_in), .stack_win(stack_win), .tmpl_word(tmpl_word),
        .tmpl_idx(tmpl_idx), .busy(busy), .done(done), .heap_we(heap_we),
        .heap_addr0(heap_addr0), .heap_addr1(heap_addr1),
        .heap_data0(heap_data0), .heap_data1(heap_data1),
        .hsize_out(hsize_out), .arg_err(arg_err)
    );

    function automatic logic [ATW-1:0] mk(kind_t k, logic s, int p);
        return {k, s, PW'(p)};
    endfunction

    function automatic logic [APPW-1:0] app(logic [ATW-1:0] a3, logic [ATW-1:0] a2,
                                            logic [ATW-1:0] a1, logic [ATW-1:0] a0);
        return {a3, a2, a1, a0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic record();
        if (heap_we != 2'b00) wrc++;
        if (heap_we[0]) begin hm[heap_addr0[7:0]] = heap_data0; hw[heap_addr0[7:0]] = 1'b1; end
        if (heap_we[1]) begin hm[heap_addr1[7:0]] = heap_data1; hw[heap_addr1[7:0]] = 1'b1; end
    endtask

    // run one instantiation; cyc = RUN cycles until done, wrc = write cycles
    task automatic inst(input int n, input int h, input bit poke);
        for (int i = 0; i < 256; i++) hw[i] = 1'b0;
        @(negedge clk);
        start = 1'b1; n_apps = CW'(n); hsize_in = PW'(h);
        @(negedge clk);
        start = 1'b0;
        cyc = 0; wrc = 0;
        record();
        while (!done && cyc < 50) begin
            if (poke && cyc == 0) begin
                start = 1'b1; n_apps = CW'(10); hsize_in = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            record();
        end
        start = 1'b0;
        if (!done) chk(1'b0, "R5 done reached", 0, 1);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !arg_err, "R10 idle flags", {busy, done, arg_err}, 0);
        chk(heap_we == 2'b00, "R10 heap_we", heap_we, 0);
        chk(hsize_out == '0, "R10 hsize_out", hsize_out, 0);
    endtask

    task automatic t_args();
        tm[0] = {app(mk(K_INT,0,7), mk(K_INT,0,7), mk(K_INT,0,7), mk(K_ARG,0,7)),
                 app(mk(K_ARG,0,2), mk(K_ARG,1,5), mk(K_ARG,0,6), mk(K_ARG,1,0))};
        inst(2, 10, 1'b0);
        chk(hw[10] && hm[10] == app(mk(K_APP,0,202), mk(K_APP,1,205), mk(K_APP,1,206), mk(K_APP,1,200)),
            "R1 R2 argument copy and dash", hm[10], app(mk(K_APP,0,202), mk(K_APP,1,205), mk(K_APP,1,206), mk(K_APP,1,200)));
        chk(hw[11] && hm[11] == app(mk(K_INT,0,7), mk(K_INT,0,7), mk(K_INT,0,7), mk(K_APP,0,207)),
            "R1 lane1 argument", hm[11], app(mk(K_INT,0,7), mk(K_INT,0,7), mk(K_INT,0,7), mk(K_APP,0,207)));
        chk(!arg_err, "R7 no error in range", arg_err, 0);
    endtask

    task automatic t_apps();
        tm[0] = {app(mk(K_FUN,1,9), mk(K_APP,0,1), mk(K_INT,0,0), mk(K_APP,1,15)),
                 app(mk(K_APP,1,3), mk(K_APP,0,0), mk(K_INT,1,12'hABC), mk(K_FUN,0,55))};
        inst(2, 40, 1'b0);
        chk(hm[40] == app(mk(K_APP,1,43), mk(K_APP,0,40), mk(K_INT,1,12'hABC), mk(K_FUN,0,55)),
            "R3 R4 lane0", hm[40], app(mk(K_APP,1,43), mk(K_APP,0,40), mk(K_INT,1,12'hABC), mk(K_FUN,0,55)));
        chk(hm[41] == app(mk(K_FUN,1,9), mk(K_APP,0,41), mk(K_INT,0,0), mk(K_APP,1,55)),
            "R3 R4 lane1", hm[41], app(mk(K_FUN,1,9), mk(K_APP,0,41), mk(K_INT,0,0), mk(K_APP,1,55)));
        chk(hsize_out == PW'(42), "R6 size after two", hsize_out, 42);
        chk(cyc == 1, "R5 one cycle for two", cyc, 1);
    endtask

    task automatic t_wrap();
        tm[0] = {app(mk(K_INT,0,1), mk(K_INT,0,1), mk(K_INT,0,1), mk(K_INT,0,1)),
                 app(mk(K_INT,0,0), mk(K_INT,0,0), mk(K_INT,0,0), mk(K_APP,0,4))};
        inst(2, 4094, 1'b0);
        chk(hsize_out == PW'(0), "R6 size wraps", hsize_out, 0);
    endtask

    task automatic t_odd();
        tm[0] = {app(mk(K_INT,0,2), mk(K_INT,0,2), mk(K_INT,0,2), mk(K_INT,0,2)),
                 app(mk(K_INT,0,1), mk(K_INT,0,1), mk(K_INT,0,1), mk(K_INT,0,1))};
        tm[1] = {app(mk(K_INT,0,9), mk(K_INT,0,9), mk(K_INT,0,9), mk(K_INT,0,9)),
                 app(mk(K_INT,0,3), mk(K_INT,0,3), mk(K_INT,0,3), mk(K_INT,0,3))};
        inst(3, 100, 1'b0);
        chk(hw[100] && hw[101] && hw[102] && hm[102] == app(mk(K_INT,0,3), mk(K_INT,0,3), mk(K_INT,0,3), mk(K_INT,0,3)),
            "R5 three rows in order", hm[102], app(mk(K_INT,0,3), mk(K_INT,0,3), mk(K_INT,0,3), mk(K_INT,0,3)));
        chk(!hw[103], "R5 lane1 off on odd tail", hw[103], 0);
        chk(cyc == 2 && wrc == 2, "R5 ceil(n/2) cycles", cyc, 2);
        chk(hsize_out == PW'(103), "R6 size after three", hsize_out, 103);
    endtask

    task automatic t_empty();
        inst(0, 77, 1'b0);
        chk(cyc == 0, "R8 done next cycle", cyc, 0);
        chk(wrc == 0, "R8 no writes", wrc, 0);
        chk(hsize_out == PW'(77), "R8 size kept", hsize_out, 77);
    endtask

    task automatic t_err();
        tm[0] = {app(mk(K_INT,0,0), mk(K_INT,0,0), mk(K_INT,0,0), mk(K_INT,0,0)),
                 app(mk(K_INT,0,1), mk(K_ARG,1,9), mk(K_INT,0,2), mk(K_INT,0,3))};
        inst(1, 20, 1'b0);
        chk(hm[20] == app(mk(K_INT,0,1), '0, mk(K_INT,0,2), mk(K_INT,0,3)),
            "R7 zero atom", hm[20], app(mk(K_INT,0,1), '0, mk(K_INT,0,2), mk(K_INT,0,3)));
        chk(arg_err, "R7 error raised", arg_err, 1);
        @(negedge clk);
        chk(arg_err, "R7 error held", arg_err, 1);
        tm[0] = {app(mk(K_INT,0,0), mk(K_INT,0,0), mk(K_INT,0,0), mk(K_INT,0,0)),
                 app(mk(K_ARG,0,7), mk(K_INT,0,2), mk(K_INT,0,2), mk(K_INT,0,2))};
        inst(1, 30, 1'b0);
        chk(!arg_err, "R7 cleared by start", arg_err, 0);
    endtask

    task automatic t_busy();
        for (int i = 0; i < 2; i++)
            tm[i] = {app(mk(K_INT,0,i), mk(K_INT,0,i), mk(K_INT,0,i), mk(K_INT,0,i)),
                     app(mk(K_APP,0,1), mk(K_INT,0,i), mk(K_INT,0,i), mk(K_INT,0,i))};
        inst(4, 60, 1'b1);
        chk(hsize_out == PW'(64) && wrc == 2, "R9 start ignored while busy", hsize_out, 64);
        chk(hm[62] == app(mk(K_APP,0,61), mk(K_INT,0,1), mk(K_INT,0,1), mk(K_INT,0,1)),
            "R9 base kept", hm[62], app(mk(K_APP,0,61), mk(K_INT,0,1), mk(K_INT,0,1), mk(K_INT,0,1)));
        @(negedge clk);
        chk(!busy && !done, "R9 back to idle", {busy, done}, 0);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) tm[i] = '0;
        for (int i = 0; i < DEPTH; i++)
            stack_win[i*ATW +: ATW] = mk(K_APP, (i == 6), 200 + i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_args();
        t_apps();
        t_wrap();
        t_odd();
        t_empty();
        t_err();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule